// File: doc/BRIEF.md
# Inverted Page Table Lookup Engine

This block turns a (process ID, virtual page number) pair into a physical frame number. The table behind it holds one entry per physical frame. Each entry records which page of which process currently lives in that frame, plus a valid flag, a chain-valid flag and a chain index. Because the table is organised by frame, the position of the matching entry is itself the frame number. The frame number is then joined to the page offset to form the physical address.

A request is hashed by XOR-folding the page number into a table index, which is where the walk starts. The engine reads one entry per cycle and compares it with the request. When the entry does not match and its chain-valid flag is set, the walk moves on to the index stored in the entry. The walk ends with a hit, with a fault when the chain runs out, or with a fault flagged as an aborted loop once it has read as many entries as the table holds. The response carries the number of entries read. A write port fills or overwrites table entries. Filling the table after a fault and choosing which frame to evict are left to the surrounding system.

Top module: `ipt_lookup`

## Requirements
- R1: The first entry read for a request is at index `h`. `h` is the XOR of all IDX_W-bit slices of the page number, with the top slice zero-padded. With the default widths, h = vpn[3:0] ^ vpn[7:4] ^ vpn[11:8]. A hit on that first entry reports a probe count of 1.
- R2: An entry matches only when its valid flag is set and both its stored page number and its process ID equal the request. A match gives `rsp_hit`=1. It also gives `rsp_frame` equal to the entry's index and `rsp_paddr` = {frame, offset}, with the frame in the upper IDX_W bits.
- R3: When an entry does not match and its chain-valid flag is set, the next entry read is at the entry's chain index. `rsp_probes` equals the number of entries read.
- R4: When a non-matching entry has its chain-valid flag clear, the engine responds with `rsp_fault`=1 and `rsp_hit`=0. On that fault, `rsp_frame` and `rsp_paddr` are zero.
- R5: When the walk has read 2^IDX_W entries without a match and the chain still continues, the walk ends. The response is `rsp_fault`=1, `rsp_loop`=1 and `rsp_probes`=2^IDX_W. `rsp_loop` is 0 on every other response.
- R6: `req_ready` is high only while the engine is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. For a request taken at edge E that reads p entries, `rsp_valid` is high for exactly the one cycle after edge E+p.
- R7: After reset, `req_ready`=1 and `rsp_valid`=0, and every table entry has its valid and chain-valid flags clear. A lookup on the empty table therefore faults after 1 probe.
- R8: A write that lands on the same edge that ends a probe of that entry does not affect that probe, which uses the old contents. Later lookups see the new contents.
- R9: An entry whose valid flag is clear never matches, even when its page number and process ID are equal to the request. Its chain is still followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_pid | input | PID_W | Process ID of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_ofs | input | OFS_W | Page offset of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | No translation found |
| rsp_loop | output | 1 | Walk aborted at the probe limit |
| rsp_frame | output | IDX_W | Frame number (index of the matching entry) |
| rsp_paddr | output | IDX_W+OFS_W | Physical address {frame, offset} |
| rsp_probes | output | IDX_W+1 | Number of entries read |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | IDX_W | Index of the entry written |
| wr_valid | input | 1 | Valid flag to store |
| wr_pid | input | PID_W | Process ID to store |
| wr_vpn | input | VPN_W | Page number to store |
| wr_chain_vld | input | 1 | Chain-valid flag to store |
| wr_chain | input | IDX_W | Chain index to store |

## Verification
A table write and a probe can both act on the same entry in the same cycle. The read is combinational, so the write commits on the edge where the probe is decided. The bench provokes this by asserting the write port in the cycle just after a request is taken, aimed at the entry the hash points to. It then requires the response to reflect the entry as it was before the write. Two follow-up lookups show that the new contents take effect from then on: the old owner now misses and the new owner hits.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_DONE  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 12,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int FOLDS = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = FOLDS * IDX_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(vpn);

  always_comb begin
    idx = '0;
    for (int i = 0; i < FOLDS; i++) begin
      idx = idx ^ padded[i*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int VPN_W = 12,
  parameter int PID_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_chain_vld,
  input  logic [IDX_W-1:0] wr_chain,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn,
  output logic             rd_chain_vld,
  output logic [IDX_W-1:0] rd_chain
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 1 + PID_W + VPN_W + 1 + IDX_W;

  logic [ENT_W-1:0] wr_word;
  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [ENT_W-1:0] rd_word;

  assign wr_word = {wr_valid, wr_pid, wr_vpn, wr_chain_vld, wr_chain};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (ent_en) begin
        ent_q[g] <= wr_word;
      end
    end
  end

  assign rd_word = ent_q[rd_idx];
  assign {rd_valid, rd_pid, rd_vpn, rd_chain_vld, rd_chain} = rd_word;
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int VPN_W = 12,
  parameter int PID_W = 4,
  parameter int IDX_W = 4,
  parameter int OFS_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFS_W-1:0]       req_ofs,
  input  logic [IDX_W-1:0]       hash_idx,
  output logic [IDX_W-1:0]       rd_idx,
  input  logic                   ent_valid,
  input  logic [PID_W-1:0]       ent_pid,
  input  logic [VPN_W-1:0]       ent_vpn,
  input  logic                   ent_chain_vld,
  input  logic [IDX_W-1:0]       ent_chain,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   rsp_loop,
  output logic [IDX_W-1:0]       rsp_frame,
  output logic [IDX_W+OFS_W-1:0] rsp_paddr,
  output logic [IDX_W:0]         rsp_probes
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PRB_W = IDX_W + 1;
  localparam logic [PRB_W-1:0] LAST_PRB = PRB_W'(DEPTH - 1);

  walk_st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PID_W-1:0] pid_q, pid_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [PRB_W-1:0] prb_q, prb_d;
  logic             ctx_en;

  logic             hit_q, hit_d;
  logic             flt_q, flt_d;
  logic             loop_q, loop_d;
  logic [IDX_W-1:0] frm_q, frm_d;
  logic [PRB_W-1:0] rprb_q, rprb_d;
  logic             rsp_en;

  logic cmp_match;
  logic at_limit;

  assign cmp_match = ent_valid && (ent_vpn == vpn_q) && (ent_pid == pid_q);
  assign at_limit  = (prb_q == LAST_PRB);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    pid_d  = pid_q;
    vpn_d  = vpn_q;
    ofs_d  = ofs_q;
    prb_d  = prb_q;
    ctx_en = 1'b0;
    hit_d  = 1'b0;
    flt_d  = 1'b0;
    loop_d = 1'b0;
    frm_d  = '0;
    rprb_d = prb_q + PRB_W'(1);
    rsp_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_PROBE;
          idx_d  = hash_idx;
          pid_d  = req_pid;
          vpn_d  = req_vpn;
          ofs_d  = req_ofs;
          prb_d  = '0;
          ctx_en = 1'b1;
        end
      end
      ST_PROBE: begin
        if (cmp_match) begin
          st_d   = ST_DONE;
          hit_d  = 1'b1;
          frm_d  = idx_q;
          rsp_en = 1'b1;
        end else if (!ent_chain_vld) begin
          st_d   = ST_DONE;
          flt_d  = 1'b1;
          rsp_en = 1'b1;
        end else if (at_limit) begin
          st_d   = ST_DONE;
          flt_d  = 1'b1;
          loop_d = 1'b1;
          rsp_en = 1'b1;
        end else begin
          idx_d  = ent_chain;
          prb_d  = prb_q + PRB_W'(1);
          ctx_en = 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pid_q <= '0;
      vpn_q <= '0;
      ofs_q <= '0;
      prb_q <= '0;
    end else if (ctx_en) begin
      idx_q <= idx_d;
      pid_q <= pid_d;
      vpn_q <= vpn_d;
      ofs_q <= ofs_d;
      prb_q <= prb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      flt_q  <= 1'b0;
      loop_q <= 1'b0;
      frm_q  <= '0;
      rprb_q <= '0;
    end else if (rsp_en) begin
      hit_q  <= hit_d;
      flt_q  <= flt_d;
      loop_q <= loop_d;
      frm_q  <= frm_d;
      rprb_q <= rprb_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rd_idx     = idx_q;
  assign rsp_valid  = (st_q == ST_DONE);
  assign rsp_hit    = hit_q;
  assign rsp_fault  = flt_q;
  assign rsp_loop   = loop_q;
  assign rsp_frame  = frm_q;
  assign rsp_paddr  = hit_q ? {frm_q, ofs_q} : '0;
  assign rsp_probes = rprb_q;
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int VPN_W = 12,
  parameter int PID_W = 4,
  parameter int IDX_W = 4,
  parameter int OFS_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFS_W-1:0]       req_ofs,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   rsp_loop,
  output logic [IDX_W-1:0]       rsp_frame,
  output logic [IDX_W+OFS_W-1:0] rsp_paddr,
  output logic [IDX_W:0]         rsp_probes,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_valid,
  input  logic [PID_W-1:0]       wr_pid,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic                   wr_chain_vld,
  input  logic [IDX_W-1:0]       wr_chain
);
  logic [IDX_W-1:0] hash_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             ent_valid;
  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;
  logic             ent_chain_vld;
  logic [IDX_W-1:0] ent_chain;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn (req_vpn),
    .idx (hash_idx)
  );

  ipt_table #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_valid     (wr_valid),
    .wr_pid       (wr_pid),
    .wr_vpn       (wr_vpn),
    .wr_chain_vld (wr_chain_vld),
    .wr_chain     (wr_chain),
    .rd_idx       (rd_idx),
    .rd_valid     (ent_valid),
    .rd_pid       (ent_pid),
    .rd_vpn       (ent_vpn),
    .rd_chain_vld (ent_chain_vld),
    .rd_chain     (ent_chain)
  );

  ipt_walker #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_pid       (req_pid),
    .req_vpn       (req_vpn),
    .req_ofs       (req_ofs),
    .hash_idx      (hash_idx),
    .rd_idx        (rd_idx),
    .ent_valid     (ent_valid),
    .ent_pid       (ent_pid),
    .ent_vpn       (ent_vpn),
    .ent_chain_vld (ent_chain_vld),
    .ent_chain     (ent_chain),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_fault     (rsp_fault),
    .rsp_loop      (rsp_loop),
    .rsp_frame     (rsp_frame),
    .rsp_paddr     (rsp_paddr),
    .rsp_probes    (rsp_probes)
  );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int IDX_W = 4,
  parameter int OFS_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   rsp_fault,
  input logic                   rsp_loop,
  input logic [IDX_W-1:0]       rsp_frame,
  input logic [IDX_W+OFS_W-1:0] rsp_paddr,
  input logic [IDX_W:0]         rsp_probes
);
  localparam int DEPTH = 1 << IDX_W;

  p_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_fault}) == 1);

  p_hit_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_paddr[IDX_W+OFS_W-1:OFS_W] == rsp_frame);

  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_frame == '0 && rsp_paddr == '0));

  p_loop_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_loop) |-> (rsp_fault && rsp_probes == (IDX_W+1)'(DEPTH)));

  p_probe_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes != '0 && rsp_probes <= (IDX_W+1)'(DEPTH)));

  p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind ipt_lookup ipt_lookup_chk #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_loop   (rsp_loop),
  .rsp_frame  (rsp_frame),
  .rsp_paddr  (rsp_paddr),
  .rsp_probes (rsp_probes)
);

// File: tb/tb_ipt_lookup.sv
module tb_ipt_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 12;
  localparam int PID_W = 4;
  localparam int IDX_W = 4;
  localparam int OFS_W = 8;
  localparam int NVEC  = 7;

  // vector: pid[26:23] vpn[22:11] hit[10] frame[9:6] probes[5:1] loop[0]
  localparam logic [26:0] VEC [NVEC] = '{
    {4'd1, 12'h123, 1'b1, 4'd0, 5'd1,  1'b0},
    {4'd2, 12'h123, 1'b1, 4'd9, 5'd3,  1'b0},
    {4'd3, 12'h123, 1'b0, 4'd0, 5'd3,  1'b0},
    {4'd0, 12'h456, 1'b1, 4'd2, 5'd2,  1'b0},
    {4'd0, 12'h00B, 1'b0, 4'd0, 5'd16, 1'b1},
    {4'd5, 12'h001, 1'b0, 4'd0, 5'd1,  1'b0},
    {4'd2, 12'h300, 1'b0, 4'd0, 5'd1,  1'b0}
  };

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [PID_W-1:0] req_pid;
  logic [VPN_W-1:0] req_vpn;
  logic [OFS_W-1:0] req_ofs;
  logic rsp_valid, rsp_hit, rsp_fault, rsp_loop;
  logic [IDX_W-1:0] rsp_frame;
  logic [IDX_W+OFS_W-1:0] rsp_paddr;
  logic [IDX_W:0] rsp_probes;
  logic wr_en, wr_valid, wr_chain_vld;
  logic [IDX_W-1:0] wr_idx, wr_chain;
  logic [PID_W-1:0] wr_pid;
  logic [VPN_W-1:0] wr_vpn;

  int checks = 0;
  int errors = 0;
  int lat;
  logic c_hit, c_fault, c_loop;
  logic [IDX_W-1:0] c_frame;
  logic [IDX_W+OFS_W-1:0] c_paddr;
  logic [IDX_W:0] c_probes;

  ipt_lookup #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_loop(rsp_loop), .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr),
    .rsp_probes(rsp_probes),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_pid(wr_pid),
    .wr_vpn(wr_vpn), .wr_chain_vld(wr_chain_vld), .wr_chain(wr_chain)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_wr(input logic [IDX_W-1:0] idx, input logic v, input logic [PID_W-1:0] pid,
                        input logic [VPN_W-1:0] vpn, input logic cv, input logic [IDX_W-1:0] ch);
    wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_pid = pid;
    wr_vpn = vpn; wr_chain_vld = cv; wr_chain = ch;
  endtask

  task automatic write_entry(input logic [IDX_W-1:0] idx, input logic v, input logic [PID_W-1:0] pid,
                             input logic [VPN_W-1:0] vpn, input logic cv, input logic [IDX_W-1:0] ch);
    @(negedge clk);
    set_wr(idx, v, pid, vpn, cv, ch);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issues one lookup; optional write lands on the first probe's deciding edge.
  task automatic lookup(input logic [PID_W-1:0] pid, input logic [VPN_W-1:0] vpn,
                        input logic [OFS_W-1:0] ofs, input bit side_wr,
                        input logic [IDX_W-1:0] s_idx, input logic [PID_W-1:0] s_pid,
                        input logic [VPN_W-1:0] s_vpn);
    @(negedge clk);
    check("R6", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_pid = pid; req_vpn = vpn; req_ofs = ofs;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6", "ready while busy", int'(req_ready), 0);
    if (side_wr) set_wr(s_idx, 1'b1, s_pid, s_vpn, 1'b0, '0);
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      wr_en = 1'b0;
      lat++;
    end
    wr_en = 1'b0;
    c_hit = rsp_hit; c_fault = rsp_fault; c_loop = rsp_loop;
    c_frame = rsp_frame; c_paddr = rsp_paddr; c_probes = rsp_probes;
    @(negedge clk);
    check("R6", "strobe one cycle", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_pid = '0; req_vpn = '0; req_ofs = '0;
    wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_pid = '0; wr_vpn = '0;
    wr_chain_vld = 1'b0; wr_chain = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "reset ready", int'(req_ready), 1);
    check("R7", "reset rsp_valid", int'(rsp_valid), 0);

    // R7: empty table faults at the first probe
    lookup(4'd1, 12'h123, 8'h00, 1'b0, '0, '0, '0);
    check("R7", "empty fault", int'(c_fault), 1);
    check("R7", "empty probes", int'(c_probes), 1);

    // table setup
    write_entry(4'd0,  1'b1, 4'd1, 12'h123, 1'b1, 4'd5);
    write_entry(4'd5,  1'b1, 4'd2, 12'h300, 1'b1, 4'd9);
    write_entry(4'd9,  1'b1, 4'd2, 12'h123, 1'b0, 4'd0);
    write_entry(4'd7,  1'b0, 4'd0, 12'h456, 1'b1, 4'd2);
    write_entry(4'd2,  1'b1, 4'd0, 12'h456, 1'b0, 4'd0);
    write_entry(4'd11, 1'b1, 4'd0, 12'h999, 1'b1, 4'd12);
    write_entry(4'd12, 1'b1, 4'd0, 12'h999, 1'b1, 4'd11);

    // vector walk: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [26:0] v;
      logic [OFS_W-1:0] ofs;
      v = VEC[i];
      ofs = OFS_W'(8'h11 * (i + 1));
      lookup(v[26:23], v[22:11], ofs, 1'b0, '0, '0, '0);
      check("R2", $sformatf("vec%0d hit", i), int'(c_hit), int'(v[10]));
      check("R4", $sformatf("vec%0d fault", i), int'(c_fault), int'(!v[10]));
      check("R3", $sformatf("vec%0d probes", i), int'(c_probes), int'(v[5:1]));
      check("R5", $sformatf("vec%0d loop", i), int'(c_loop), int'(v[0]));
      check("R6", $sformatf("vec%0d latency", i), lat, int'(v[5:1]));
      if (v[10]) begin
        check("R1", $sformatf("vec%0d frame", i), int'(c_frame), int'(v[9:6]));
        check("R2", $sformatf("vec%0d paddr", i), int'(c_paddr), int'({v[9:6], ofs}));
      end else begin
        check("R4", $sformatf("vec%0d paddr zero", i), int'(c_paddr), 0);
      end
    end

    // R8: write lands on the probe's deciding edge
    write_entry(4'd4, 1'b1, 4'd3, 12'h004, 1'b0, 4'd0);
    lookup(4'd3, 12'h004, 8'h5A, 1'b1, 4'd4, 4'd6, 12'h004);
    check("R8", "old contents hit", int'(c_hit), 1);
    check("R8", "old contents frame", int'(c_frame), 4);
    lookup(4'd3, 12'h004, 8'h5A, 1'b0, '0, '0, '0);
    check("R8", "old owner now misses", int'(c_fault), 1);
    lookup(4'd6, 12'h004, 8'hA5, 1'b0, '0, '0, '0);
    check("R8", "new owner hits", int'(c_hit), 1);
    check("R8", "new owner paddr", int'(c_paddr), int'({4'd4, 8'hA5}));

    // R9: invalid entry with equal fields does not match, chain still followed
    write_entry(4'd2, 1'b0, 4'd0, 12'h456, 1'b0, 4'd0);
    lookup(4'd0, 12'h456, 8'h01, 1'b0, '0, '0, '0);
    check("R9", "invalid no match", int'(c_hit), 0);
    check("R9", "invalid chain probes", int'(c_probes), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule